// File: doc/BRIEF.md
# Interleaved SAR Sequencer with Output Multiplexer

This block is the digital core of a time-interleaved successive-approximation converter. Sixteen identical SAR sections share one analog input. A free-running phase counter staggers them by one clock each, so on every clock exactly one section takes a sample and exactly one section hands over a finished word. Each section follows a fixed sixteen-slot frame. The frame runs a reference-zero sample, an offset compare, a gain-calibration compare and the input sample. Eleven SAR decision slots follow, most significant bit first, and the frame ends with a hand-over slot.

The analog comparators sit outside the block. Each section drives out its current trial word, and its comparator returns one decision bit per clock. The block also drives one-hot strobes that tell the analog side which section samples, zeroes or calibrates on the current clock. A 16:1 multiplexer picks the word of the section in its hand-over slot. A registered output stage turns that word into ten straight-binary bits plus an overrange flag, with saturation, and raises a data-valid flag for words that come from a complete conversion. An active-low enable input controls the pad drivers of the data bus.

Top module: `tisar_top`

## Requirements
- R1: After reset is released, call the first clock cycle 0. In cycle c, `smp_o` has exactly one bit set, bit (c+13) mod 16, so section k samples in slot 3 of its frame. The pattern repeats every 16 cycles.
- R2: In cycle c, `rzero_o` is one-hot at bit c mod 16 (slot 0), `azero_o` is one-hot at bit (c+15) mod 16 (slot 1) and `acal_o` is one-hot at bit (c+14) mod 16 (slot 2).
- R3: In SAR slots 4 to 14, a section tests bit 14 minus slot, starting at bit 10. Its trial word on `trial_o` (section k at bits k*11 to k*11+10) is its kept bits plus the trial bit. The section keeps the trial bit when its `cmp_i` bit is 1. The final word is the largest 11-bit code whose trial the comparator accepted.
- R4: A section ignores its `cmp_i` bit in every slot other than 4 to 14. Its word does not change from the hand-over slot through the calibration slots.
- R5: The word sampled in cycle c appears on `dout_o` in cycle c+13, after 12 rising edges following the end of the sample slot.
- R6: A conversion result from 0 to 1023 appears as straight binary: `dout_o[9:0]` equals the result and `dout_o[10]` is 0.
- R7: A result of 1024 or more sets the overrange bit `dout_o[10]` to 1 and forces `dout_o[9:0]` to all ones.
- R8: `dav_o` is 0 during reset and in cycles 0 to 12. From cycle 13 on it is 1 and stays 1 until the next reset.
- R9: `dout_oe_o` is 1 exactly when `oe_n` is 0. `oe_n` has no effect on the words produced.
- R10: A synchronous reset clears the phase counter, every section word and the output register. During reset `dout_o` is 0 and `smp_o` selects section 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output pad enable, active low |
| cmp_i | input | 16 | Comparator decision per section, 1 = input at or above trial level |
| smp_o | output | 16 | One-hot: section taking the input sample this cycle |
| rzero_o | output | 16 | One-hot: section sampling the zero reference this cycle |
| azero_o | output | 16 | One-hot: section doing its offset compare this cycle |
| acal_o | output | 16 | One-hot: section doing its gain-calibration compare this cycle |
| trial_o | output | 176 | Trial word per section, 11 bits each, section k at k*11 |
| dout_o | output | 11 | Registered output word: bit 10 overrange, bits 9..0 straight binary |
| dav_o | output | 1 | Output word comes from a complete conversion |
| dout_oe_o | output | 1 | Pad drive enable for the data bus, 1 = drive, 0 = high impedance |

## Verification
The inline assertions watch the every-cycle invariants. They check the counter step and wrap, that each strobe set and the hand-over select stay one-hot, and that a section's word stays frozen outside the SAR and sample slots. They also check that bits at and below the bit under test are clear during the search, that overrange implies an all-ones data field, that valid never drops without reset, and that reset empties the output register. Only the bench scenarios can show the slot positions of the strobes, the true 13-cycle alignment of each input value with its word, and correct results under a comparator that returns noise in non-SAR slots. They also show the saturation boundary at 1023/1024, the effect of a reset in mid-stream, and that the enable pin leaves the data stream untouched.

// File: rtl/tisar_pkg.sv
`timescale 1ns/1ps
package tisar_pkg;

  // Slots ahead of the SAR search inside one section frame
  localparam int SLOT_REFZ   = 0;
  localparam int SLOT_AZERO  = 1;
  localparam int SLOT_ACAL   = 2;
  localparam int SLOT_SAMPLE = 3;
  localparam int SLOT_SAR0   = 4;

  typedef enum logic [2:0] {
    SK_REFZ,
    SK_AZERO,
    SK_ACAL,
    SK_SAMPLE,
    SK_SAR,
    SK_XFER
  } slot_kind_e;

  // Frame length follows from the search width: 4 lead slots, search, hand-over
  function automatic int frame_len(input int sar_w);
    return SLOT_SAR0 + sar_w + 1;
  endfunction

  // Slot of a section given the phase count and its stagger index
  function automatic int slot_of(input int cnt, input int idx, input int nsec);
    int s;
    s = cnt + nsec - idx;
    if (s >= nsec) s = s - nsec;
    return s;
  endfunction

  function automatic slot_kind_e slot_kind(input int slot, input int sar_w);
    if (slot == SLOT_REFZ)          return SK_REFZ;
    else if (slot == SLOT_AZERO)    return SK_AZERO;
    else if (slot == SLOT_ACAL)     return SK_ACAL;
    else if (slot == SLOT_SAMPLE)   return SK_SAMPLE;
    else if (slot < SLOT_SAR0 + sar_w) return SK_SAR;
    else                            return SK_XFER;
  endfunction

  // Bit under test in a SAR slot, MSB first
  function automatic int sar_bitpos(input int slot, input int sar_w);
    return sar_w - 1 - (slot - SLOT_SAR0);
  endfunction

endpackage

// File: rtl/tisar_phase_gen.sv
`timescale 1ns/1ps
module tisar_phase_gen #(
  parameter int NSEC = 16,
  localparam int CW = $clog2(NSEC)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == CW'(NSEC - 1));

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (at_last) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R1: the phase advances by one per clock and wraps after NSEC
  assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(NSEC - 1)) |=> (cnt_q == '0));
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != CW'(NSEC - 1)) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/tisar_section.sv
`timescale 1ns/1ps
module tisar_section
  import tisar_pkg::*;
#(
  parameter int SAR_W = 11,
  parameter int NSEC  = 16,
  parameter int IDX   = 0,
  localparam int CW   = $clog2(NSEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    cnt_i,
  input  logic             cmp_i,
  output logic [SAR_W-1:0] trial_o,
  output logic [SAR_W-1:0] word_o,
  output logic             vld_o,
  output logic             is_refz_o,
  output logic             is_azero_o,
  output logic             is_acal_o,
  output logic             is_smp_o,
  output logic             is_xfer_o
);

  slot_kind_e       kind;
  int               slot;
  int               bitpos;
  logic [SAR_W-1:0] acc_q;
  logic             vld_q;
  logic [SAR_W-1:0] tbit;
  logic [SAR_W-1:0] low_mask;
  logic             is_sar;
  logic             keep_bit;

  always_comb begin
    slot   = slot_of(int'(cnt_i), IDX, NSEC);
    kind   = slot_kind(slot, SAR_W);
    is_sar = (kind == SK_SAR);
    bitpos = is_sar ? sar_bitpos(slot, SAR_W) : 0;
    tbit   = is_sar ? (SAR_W'(1) << bitpos) : '0;
    // bits at and below the bit under test
    low_mask = (tbit << 1) - SAR_W'(1);
    keep_bit = is_sar && cmp_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      unique case (kind)
        SK_SAMPLE: begin
          acc_q <= '0;
          vld_q <= 1'b1;
        end
        SK_SAR: begin
          if (keep_bit) acc_q <= acc_q | tbit;
        end
        default: ;
      endcase
    end
  end

  assign trial_o    = acc_q | tbit;
  assign word_o     = acc_q;
  assign vld_o      = vld_q;
  assign is_refz_o  = (kind == SK_REFZ);
  assign is_azero_o = (kind == SK_AZERO);
  assign is_acal_o  = (kind == SK_ACAL);
  assign is_smp_o   = (kind == SK_SAMPLE);
  assign is_xfer_o  = (kind == SK_XFER);

  // R3: untested bits are still clear while the search runs
  assert_sar_low_clear_R3: assert property (@(posedge clk) disable iff (rst)
    is_sar |-> ((acc_q & low_mask) == '0));

  // R4: comparator has no effect from hand-over through calibration slots
  assert_cal_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (kind inside {SK_XFER, SK_REFZ, SK_AZERO, SK_ACAL}) |=> $stable(acc_q));

  // R10: a section word is empty on the cycle after reset
  assert_sec_rst_R10: assert property (@(posedge clk)
    $past(rst) |-> ((acc_q == '0) && !vld_q));

endmodule

// File: rtl/tisar_outstage.sv
`timescale 1ns/1ps
module tisar_outstage #(
  parameter int RES_W = 10,
  parameter int NSEC  = 16,
  localparam int SAR_W = RES_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSEC-1:0]       xfer_i,
  input  logic [NSEC*SAR_W-1:0] words_i,
  input  logic [NSEC-1:0]       vlds_i,
  output logic [RES_W:0]        dout_o,
  output logic                  dav_o
);

  logic [SAR_W-1:0] sel_word;
  logic             sel_vld;
  logic [RES_W:0]   dout_q;
  logic             dav_q;

  // Overrange when the top search bit is set: flag plus all-ones data
  function automatic logic [RES_W:0] saturate(input logic [SAR_W-1:0] w);
    if (w[SAR_W-1]) return '1;
    else            return {1'b0, w[RES_W-1:0]};
  endfunction

  always_comb begin
    sel_word = '0;
    sel_vld  = 1'b0;
    for (int k = 0; k < NSEC; k++) begin
      if (xfer_i[k]) begin
        sel_word = sel_word | words_i[k*SAR_W +: SAR_W];
        sel_vld  = sel_vld | vlds_i[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dav_q  <= 1'b0;
    end else begin
      dout_q <= saturate(sel_word);
      dav_q  <= sel_vld;
    end
  end

  assign dout_o = dout_q;
  assign dav_o  = dav_q;

  // R5: exactly one section hands over on every clock
  assert_xfer_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(xfer_i) == 1);

  // R7: overrange flag always comes with a saturated data field
  assert_ovr_sat_R7: assert property (@(posedge clk) disable iff (rst)
    dout_q[RES_W] |-> (&dout_q[RES_W-1:0]));

  // R8: once valid, valid holds until reset
  assert_dav_hold_R8: assert property (@(posedge clk) disable iff (rst)
    dav_q |=> dav_q);

  // R10: reset empties the output register
  assert_out_rst_R10: assert property (@(posedge clk)
    $past(rst) |-> ((dout_q == '0) && !dav_q));

endmodule

// File: rtl/tisar_top.sv
`timescale 1ns/1ps
module tisar_top
  import tisar_pkg::*;
#(
  parameter int RES_W = 10,
  localparam int SAR_W = RES_W + 1,
  localparam int NSEC  = frame_len(SAR_W),
  localparam int CW    = $clog2(NSEC)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  oe_n,
  input  logic [NSEC-1:0]       cmp_i,
  output logic [NSEC-1:0]       smp_o,
  output logic [NSEC-1:0]       rzero_o,
  output logic [NSEC-1:0]       azero_o,
  output logic [NSEC-1:0]       acal_o,
  output logic [NSEC*SAR_W-1:0] trial_o,
  output logic [RES_W:0]        dout_o,
  output logic                  dav_o,
  output logic                  dout_oe_o
);

  logic [CW-1:0]          cnt;
  logic [NSEC*SAR_W-1:0]  words;
  logic [NSEC-1:0]        vlds;
  logic [NSEC-1:0]        xfer;

  tisar_phase_gen #(.NSEC(NSEC)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (cnt)
  );

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    tisar_section #(.SAR_W(SAR_W), .NSEC(NSEC), .IDX(k)) u_sec (
      .clk        (clk),
      .rst        (rst),
      .cnt_i      (cnt),
      .cmp_i      (cmp_i[k]),
      .trial_o    (trial_o[k*SAR_W +: SAR_W]),
      .word_o     (words[k*SAR_W +: SAR_W]),
      .vld_o      (vlds[k]),
      .is_refz_o  (rzero_o[k]),
      .is_azero_o (azero_o[k]),
      .is_acal_o  (acal_o[k]),
      .is_smp_o   (smp_o[k]),
      .is_xfer_o  (xfer[k])
    );
  end

  tisar_outstage #(.RES_W(RES_W), .NSEC(NSEC)) u_out (
    .clk     (clk),
    .rst     (rst),
    .xfer_i  (xfer),
    .words_i (words),
    .vlds_i  (vlds),
    .dout_o  (dout_o),
    .dav_o   (dav_o)
  );

  assign dout_oe_o = ~oe_n;

  // R1: exactly one section samples on every clock, never the one handing over
  assert_smp_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    ($countones(smp_o) == 1) && ((smp_o & xfer) == '0));

  // R2: calibration strobes are one-hot and never collide
  assert_cal_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    ($countones(rzero_o) == 1) && ($countones(azero_o) == 1) &&
    ($countones(acal_o) == 1) &&
    ((rzero_o & azero_o) == '0) && ((azero_o & acal_o) == '0));

  // R2: the section that zeroes now does its offset compare next clock
  assert_cal_order_R2: assert property (@(posedge clk) disable iff (rst)
    (rzero_o != '0) |=> (azero_o == $past(rzero_o)));

endmodule

// File: tb/sim_tisar_top.sv
`timescale 1ns/1ps
module sim_tisar_top;

  localparam int NS = 16;
  localparam int SW = 11;
  localparam int NV = 20;
  localparam int LAT = 13;

  // stimulus codes and expected output words (bit 10 overrange)
  localparam logic [10:0] VEC_IN [NV] = '{
    11'd0, 11'd1, 11'd2, 11'd511, 11'd512, 11'd341, 11'd682, 11'd1022,
    11'd1023, 11'd1024, 11'd1025, 11'd1500, 11'd2047, 11'd85, 11'd938,
    11'd256, 11'd768, 11'd1, 11'd1023, 11'd1024 };
  localparam logic [10:0] VEC_EXP [NV] = '{
    11'd0, 11'd1, 11'd2, 11'd511, 11'd512, 11'd341, 11'd682, 11'd1022,
    11'd1023, 11'h7FF, 11'h7FF, 11'h7FF, 11'h7FF, 11'd85, 11'd938,
    11'd256, 11'd768, 11'd1, 11'd1023, 11'h7FF };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              oe_n = 1'b0;
  logic [NS-1:0]     cmp;
  logic [NS-1:0]     smp_o, rzero_o, azero_o, acal_o;
  logic [NS*SW-1:0]  trial_o;
  logic [10:0]       dout_o;
  logic              dav_o, dout_oe_o;

  logic [10:0]       held [NS];
  logic [15:0]       noise = 16'hACE1;
  int                cur_c = 0;
  int                tests = 0;
  int                fails = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  tisar_top u0 (
    .clk(clk), .rst(rst), .oe_n(oe_n), .cmp_i(cmp),
    .smp_o(smp_o), .rzero_o(rzero_o), .azero_o(azero_o), .acal_o(acal_o),
    .trial_o(trial_o), .dout_o(dout_o), .dav_o(dav_o), .dout_oe_o(dout_oe_o)
  );

  // analog model: true compare in search slots, noise elsewhere (R4)
  always_comb begin
    for (int k = 0; k < NS; k++) begin
      int s;
      s = (cur_c + NS - k) % NS;
      if (s >= 4 && s <= 14) cmp[k] = (held[k] >= trial_o[k*SW +: SW]);
      else                   cmp[k] = noise[k];
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      logic [15:0] e_smp, e_rz, e_az, e_ac;
      if (c > 0) @(negedge clk);
      cur_c = c;
      e_smp = 16'(1) << ((c + 13) % NS);
      e_rz  = 16'(1) << (c % NS);
      e_az  = 16'(1) << ((c + 15) % NS);
      e_ac  = 16'(1) << ((c + 14) % NS);
      chk(smp_o == e_smp, "R1 sample strobe", 32'(smp_o), 32'(e_smp));
      chk(rzero_o == e_rz, "R2 zero-ref strobe", 32'(rzero_o), 32'(e_rz));
      chk(azero_o == e_az, "R2 offset strobe", 32'(azero_o), 32'(e_az));
      chk(acal_o == e_ac, "R2 gain-cal strobe", 32'(acal_o), 32'(e_ac));
      chk(dout_oe_o == !oe_n, "R9 pad enable", 32'(dout_oe_o), 32'(!oe_n));
      if (c == 0) chk(dout_o == 11'd0, "R10 output cleared", 32'(dout_o), 32'd0);
      if (c < LAT) begin
        chk(dav_o == 1'b0, "R8 valid low before first word", 32'(dav_o), 32'd0);
      end else begin
        logic [10:0] e;
        e = VEC_EXP[(c - LAT) % NV];
        chk(dav_o == 1'b1, "R8 valid high", 32'(dav_o), 32'd1);
        // word alignment R5, search R3, noise ignored R4, coding R6/R7, oe R9
        if (e[10]) chk(dout_o == e, "R7 R5 R3 R4 R9 overrange word", 32'(dout_o), 32'(e));
        else       chk(dout_o == e, "R6 R5 R3 R4 R9 binary word", 32'(dout_o), 32'(e));
      end
      oe_n = (c >= 40 && c < 60);
      held[(c + 13) % NS] = VEC_IN[c % NV];
      noise = {noise[14:0], noise[15] ^ noise[13] ^ noise[12] ^ noise[10]};
    end
  endtask

  task automatic in_reset(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_c = 0;
      chk(dout_o == 11'd0, "R10 output during reset", 32'(dout_o), 32'd0);
      chk(dav_o == 1'b0, "R8 valid during reset", 32'(dav_o), 32'd0);
      chk(smp_o == 16'h2000, "R10 phase during reset", 32'(smp_o), 32'h2000);
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    for (int k = 0; k < NS; k++) held[k] = 11'd0;
    in_reset(3);
    rst = 1'b0;
    run(220);
    // reset in mid-stream, then restart
    @(negedge clk);
    rst = 1'b1;
    in_reset(3);
    rst = 1'b0;
    run(70);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end

endmodule